// File: doc/BRIEF.md
# Flash Status and Suspend Register Unit

This block keeps the status, configuration and security registers of a serial NOR flash device model. It runs the commands that act on them: latch and clear write enable, read any of the three registers, write status with configuration, select individual-sector protection, and suspend or resume a running program or erase. Commands reach it already decoded, as a one-cycle strobe with an opcode, a status data byte and a configuration data byte.

An abstract program/erase engine sits beside it. The engine reports the start of an operation and whether it is an erase, a busy level, and a done strobe carrying a fail bit. The unit sends back a suspend request level. One suspend opcode and one resume opcode serve both kinds of operation, and the security register shows which kind was suspended. Failure flags clear by themselves when the next operation starts, so no command exists to clear them.

Top module: `flash_sr_unit`

## Requirements
- R1: After reset all outputs are 0: every register bit, susp_req, rd_valid, rd_byte and prot_bits.
- R2: Opcode 06h sets the write-enable latch and 04h clears it. The latch is status bit 1.
- R3: Status byte layout: bit 0 write-in-progress, bit 1 write enable, bits 5:2 block protect, bit 6 quad enable, bit 7 status-write lock. Opcodes 05h, 2Bh and 15h return the status, security or configuration byte as it was when the command arrived. The byte appears on rd_byte with rd_valid high for one cycle, the cycle after the strobe. rd_byte holds its value otherwise.
- R4: Opcode 01h loads data bits 5:2 into block protect, bit 6 into quad enable and bit 7 into the lock, and cmd_cfg into the configuration byte. Data bits 1:0 are ignored. The whole write is dropped when write enable is 0, or when the lock is 1 and wp_n is 0.
- R5: Write-in-progress shows eng_busy registered by one cycle. It reads 0 while an operation is suspended.
- R6: Opcode B0h, when eng_busy is 1 and no suspend is held, raises susp_req. It also sets security bit 2 if the current operation is a program, or bit 3 if it is an erase. The kind is taken from eng_erase at eng_start, including an eng_start in the same cycle.
- R7: Opcode 30h, while suspended, drops susp_req and clears security bits 2 and 3. Write-in-progress follows eng_busy again.
- R8: Opcode B0h with eng_busy at 0 or a suspend already held has no effect. Opcode 30h with no suspend held has no effect.
- R9: eng_done with eng_fail sets security bit 5 for a program or bit 6 for an erase. eng_start clears both bits, and it wins over a done strobe in the same cycle.
- R10: Opcode 68h sets security bit 7 only when write enable is 1. The bit then stays set until reset.
- R11: prot_bits always equals the four block-protect bits of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Opcode |
| cmd_data | input | 8 | Status data byte for 01h |
| cmd_cfg | input | 8 | Configuration data byte for 01h |
| wp_n | input | 1 | Write-protect input, active low |
| eng_start | input | 1 | Operation start strobe from the engine |
| eng_erase | input | 1 | 1 for erase, 0 for program, sampled at eng_start |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Operation finished strobe |
| eng_fail | input | 1 | Failure result qualifying eng_done |
| rd_valid | output | 1 | Read byte valid |
| rd_byte | output | 8 | Register read result |
| status_byte | output | 8 | Live status register |
| secur_byte | output | 8 | Live security register |
| cfg_byte | output | 8 | Live configuration register |
| susp_req | output | 1 | Suspend request to the engine |
| prot_bits | output | 4 | Block-protect vector |

## Verification
The bench attacks a status write with write enable cleared, and a status write with the lock set while wp_n is low. A design that ignored either guard would change the protect bits. It checks that write-in-progress falls during a suspend and rises again on resume. A design that left it on eng_busy alone would show a busy device that is in fact paused. Suspend and resume sent to an idle unit must leave susp_req and bits 2 and 3 unchanged. A start in the same cycle as a fail result must clear the fail flags and not set them. Random command and engine traffic is then compared against a behavioural model on every cycle.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
    localparam int BYTE_W = 8;
    localparam int BP_W   = 4;

    localparam logic [BYTE_W-1:0] OP_WREN  = 8'h06;
    localparam logic [BYTE_W-1:0] OP_WRDI  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_RDSR  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRSR  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RDSEC = 8'h2B;
    localparam logic [BYTE_W-1:0] OP_RDCFG = 8'h15;
    localparam logic [BYTE_W-1:0] OP_SUSP  = 8'hB0;
    localparam logic [BYTE_W-1:0] OP_RESM  = 8'h30;
    localparam logic [BYTE_W-1:0] OP_WPSEL = 8'h68;

    // writable status bits: 7..2
    localparam logic [BYTE_W-1:0] SR_WR_MASK = 8'hFC;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic rdsr;
        logic wrsr;
        logic rdsec;
        logic rdcfg;
        logic susp;
        logic resm;
        logic wpsel;
    } cmd_dec_t;

    typedef struct packed {
        logic              wel;
        logic [BP_W-1:0]   bp;
        logic              qe;
        logic              srwd;
        logic [BYTE_W-1:0] cfg;
        logic              wpsel;
        logic              busy;
        logic              rd_valid;
        logic [BYTE_W-1:0] rd_byte;
    } reg_st_t;

    typedef struct packed {
        logic susp;
        logic psb;
        logic esb;
        logic kind;
        logic pfail;
        logic efail;
    } susp_st_t;
endpackage

// File: rtl/flash_sr_decode.sv
module flash_sr_decode
    import flash_sr_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_op,
    output cmd_dec_t          dec
);
    always_comb begin
        dec = '0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_WREN:  dec.wren  = 1'b1;
                OP_WRDI:  dec.wrdi  = 1'b1;
                OP_RDSR:  dec.rdsr  = 1'b1;
                OP_WRSR:  dec.wrsr  = 1'b1;
                OP_RDSEC: dec.rdsec = 1'b1;
                OP_RDCFG: dec.rdcfg = 1'b1;
                OP_SUSP:  dec.susp  = 1'b1;
                OP_RESM:  dec.resm  = 1'b1;
                OP_WPSEL: dec.wpsel = 1'b1;
                default:  dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_sr_susp.sv
module flash_sr_susp
    import flash_sr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_susp,
    input  logic req_resm,
    input  logic eng_start,
    input  logic eng_erase,
    input  logic eng_busy,
    input  logic eng_done,
    input  logic eng_fail,
    output logic susp_q,
    output logic psb_q,
    output logic esb_q,
    output logic pfail_q,
    output logic efail_q
);
    susp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (eng_start) begin
            st_d.kind  = eng_erase;
            st_d.pfail = 1'b0;
            st_d.efail = 1'b0;
        end else if (eng_done && eng_fail) begin
            if (st_q.kind) st_d.efail = 1'b1;
            else           st_d.pfail = 1'b1;
        end
        if (req_susp && eng_busy && !st_q.susp) begin
            st_d.susp = 1'b1;
            st_d.psb  = !st_d.kind;
            st_d.esb  = st_d.kind;
        end else if (req_resm && st_q.susp) begin
            st_d.susp = 1'b0;
            st_d.psb  = 1'b0;
            st_d.esb  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign susp_q  = st_q.susp;
    assign psb_q   = st_q.psb;
    assign esb_q   = st_q.esb;
    assign pfail_q = st_q.pfail;
    assign efail_q = st_q.efail;

    p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.psb, st_q.esb}));
    p_susp_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.susp |-> (st_q.psb || st_q.esb));
    p_resume_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_resm && st_q.susp) |=> (!st_q.susp && !st_q.psb && !st_q.esb));
    p_idle_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_susp && !eng_busy && !st_q.susp) |=> !st_q.susp);
    p_start_clears_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> (!st_q.pfail && !st_q.efail));
endmodule

// File: rtl/flash_sr_unit.sv
module flash_sr_unit
    import flash_sr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [7:0]  cmd_op,
    input  logic [7:0]  cmd_data,
    input  logic [7:0]  cmd_cfg,
    input  logic        wp_n,
    input  logic        eng_start,
    input  logic        eng_erase,
    input  logic        eng_busy,
    input  logic        eng_done,
    input  logic        eng_fail,
    output logic        rd_valid,
    output logic [7:0]  rd_byte,
    output logic [7:0]  status_byte,
    output logic [7:0]  secur_byte,
    output logic [7:0]  cfg_byte,
    output logic        susp_req,
    output logic [3:0]  prot_bits
);
    cmd_dec_t          dec;
    reg_st_t           r_d, r_q;
    logic              susp_q, psb_q, esb_q, pfail_q, efail_q;
    logic [BYTE_W-1:0] wr_val;
    logic              wr_ok;

    flash_sr_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dec       (dec)
    );

    flash_sr_susp u_susp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_susp  (dec.susp),
        .req_resm  (dec.resm),
        .eng_start (eng_start),
        .eng_erase (eng_erase),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .eng_fail  (eng_fail),
        .susp_q    (susp_q),
        .psb_q     (psb_q),
        .esb_q     (esb_q),
        .pfail_q   (pfail_q),
        .efail_q   (efail_q)
    );

    always_comb begin
        status_byte = {r_q.srwd, r_q.qe, r_q.bp, r_q.wel, r_q.busy & ~susp_q};
        secur_byte  = {r_q.wpsel, efail_q, pfail_q, 1'b0, esb_q, psb_q, 2'b00};
    end

    always_comb begin
        wr_val = cmd_data & SR_WR_MASK;
        wr_ok  = r_q.wel && !(r_q.srwd && !wp_n);
        r_d    = r_q;
        r_d.busy     = eng_busy;
        r_d.rd_valid = 1'b0;
        if (dec.wren) r_d.wel = 1'b1;
        if (dec.wrdi) r_d.wel = 1'b0;
        if (dec.wrsr && wr_ok) begin
            r_d.bp   = wr_val[2 +: BP_W];
            r_d.qe   = wr_val[6];
            r_d.srwd = wr_val[7];
            r_d.cfg  = cmd_cfg;
        end
        if (dec.wpsel && r_q.wel) r_d.wpsel = 1'b1;
        if (dec.rdsr) begin
            r_d.rd_valid = 1'b1;
            r_d.rd_byte  = status_byte;
        end
        if (dec.rdsec) begin
            r_d.rd_valid = 1'b1;
            r_d.rd_byte  = secur_byte;
        end
        if (dec.rdcfg) begin
            r_d.rd_valid = 1'b1;
            r_d.rd_byte  = r_q.cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid  = r_q.rd_valid;
    assign rd_byte   = r_q.rd_byte;
    assign cfg_byte  = r_q.cfg;
    assign susp_req  = susp_q;
    assign prot_bits = r_q.bp;

    p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wren |=> status_byte[1]);
    p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec.wrdi |=> !status_byte[1]);
    p_read_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.rdsr || dec.rdsec || dec.rdcfg) |=> rd_valid);
    p_wrsr_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wrsr && !status_byte[1]) |=> $stable(status_byte[7:2]));
    p_wip_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> !status_byte[0]);
    p_wpsel_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        secur_byte[7] |=> secur_byte[7]);
    p_prot_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_bits == status_byte[5:2]);
endmodule

// File: tb/tb_flash_sr_unit.sv
module tb_flash_sr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00, cmd_data = 8'h00, cmd_cfg = 8'h00;
    logic       wp_n = 1'b1;
    logic       eng_start = 1'b0, eng_erase = 1'b0, eng_busy = 1'b0;
    logic       eng_done = 1'b0, eng_fail = 1'b0;
    logic       rd_valid, susp_req;
    logic [7:0] rd_byte, status_byte, secur_byte, cfg_byte;
    logic [3:0] prot_bits;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    flash_sr_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_cfg(cmd_cfg), .wp_n(wp_n),
        .eng_start(eng_start), .eng_erase(eng_erase), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_fail(eng_fail), .rd_valid(rd_valid),
        .rd_byte(rd_byte), .status_byte(status_byte), .secur_byte(secur_byte),
        .cfg_byte(cfg_byte), .susp_req(susp_req), .prot_bits(prot_bits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    bit       m_wel, m_qe, m_lock, m_wpsel, m_busy, m_susp, m_psb, m_esb;
    bit       m_erase_op, m_pf, m_ef, m_rdv;
    bit [3:0] m_bp;
    bit [7:0] m_cfg, m_rdb;

    function automatic bit [7:0] m_status();
        return {m_lock, m_qe, m_bp, m_wel, m_busy && !m_susp};
    endfunction
    function automatic bit [7:0] m_secur();
        return {m_wpsel, m_ef, m_pf, 1'b0, m_esb, m_psb, 2'b00};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_qe = 0; m_lock = 0; m_wpsel = 0; m_busy = 0;
            m_susp = 0; m_psb = 0; m_esb = 0; m_erase_op = 0;
            m_pf = 0; m_ef = 0; m_rdv = 0; m_bp = 0; m_cfg = 0; m_rdb = 0;
        end else begin
            bit [7:0] s_old, c_old;
            bit       wel_old;
            s_old = m_status(); c_old = m_secur(); wel_old = m_wel;
            m_rdv = 0;
            if (cmd_valid) begin
                if (cmd_op == 8'h06) m_wel = 1;
                if (cmd_op == 8'h04) m_wel = 0;
                if (cmd_op == 8'h05) begin m_rdv = 1; m_rdb = s_old; end
                if (cmd_op == 8'h2B) begin m_rdv = 1; m_rdb = c_old; end
                if (cmd_op == 8'h15) begin m_rdv = 1; m_rdb = m_cfg; end
                if (cmd_op == 8'h01 && wel_old && !(m_lock && !wp_n)) begin
                    m_bp = cmd_data[5:2]; m_qe = cmd_data[6];
                    m_lock = cmd_data[7]; m_cfg = cmd_cfg;
                end
                if (cmd_op == 8'h68 && wel_old) m_wpsel = 1;
            end
            if (eng_start) begin
                m_erase_op = eng_erase; m_pf = 0; m_ef = 0;
            end else if (eng_done && eng_fail) begin
                if (m_erase_op) m_ef = 1; else m_pf = 1;
            end
            if (cmd_valid && cmd_op == 8'hB0 && eng_busy && !m_susp) begin
                m_susp = 1; m_psb = !m_erase_op; m_esb = m_erase_op;
            end else if (cmd_valid && cmd_op == 8'h30 && m_susp) begin
                m_susp = 0; m_psb = 0; m_esb = 0;
            end
            m_busy = eng_busy;
        end
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check8("R3 rd_valid", {7'd0, rd_valid}, {7'd0, m_rdv});
            if (m_rdv) check8("R3 rd_byte", rd_byte, m_rdb);
            check8("R2 R4 R5 status", status_byte, m_status());
            check8("R6 R9 R10 security", secur_byte, m_secur());
            check8("R4 cfg", cfg_byte, m_cfg);
            check8("R6 R7 R8 susp_req", {7'd0, susp_req}, {7'd0, m_susp});
            check8("R11 prot", {4'd0, prot_bits}, {4'd0, m_bp});
        end
    end

    task automatic cmd(input logic [7:0] op, input logic [7:0] d = 8'h00,
                       input logic [7:0] c = 8'h00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_cfg = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(3);
        // R1: reset state
        check8("R1 status", status_byte, 8'h00);
        check8("R1 security", secur_byte, 8'h00);
        check8("R1 misc", {rd_valid, susp_req, prot_bits, 2'b00}, 8'h00);
        rst_n = 1'b1;
        cmd(8'h05);
        check8("R3 read status after reset", rd_byte, 8'h00);
        cmd(8'h01, 8'hFF, 8'h5A);            // R4: no write enable, dropped
        check8("R4 write without WEL", status_byte, 8'h00);
        cmd(8'h06);
        check8("R2 WEL set", status_byte, 8'h02);
        cmd(8'h01, 8'hFF, 8'h5A);
        check8("R4 write accepted", status_byte, 8'hFE);
        check8("R4 cfg written", cfg_byte, 8'h5A);
        wp_n = 1'b0;
        cmd(8'h01, 8'h00, 8'h00);            // R4: locked by wp_n
        check8("R4 locked write", status_byte, 8'hFE);
        wp_n = 1'b1;
        cmd(8'h01, 8'h3C, 8'h11);
        check8("R4 unlocked write", status_byte, 8'h3E);
        check8("R11 prot bits", {4'd0, prot_bits}, 8'h0F);
        cmd(8'h04);
        cmd(8'h68);
        check8("R10 WPSEL needs WEL", secur_byte, 8'h00);
        cmd(8'h06);
        cmd(8'h68);
        check8("R10 WPSEL set", secur_byte, 8'h80);
        // program with suspend
        @(negedge clk); eng_start = 1; eng_erase = 0; eng_busy = 1;
        @(negedge clk); eng_start = 0;
        check8("R5 WIP on", {7'd0, status_byte[0]}, 8'h01);
        cmd(8'hB0);
        check8("R6 program suspended", secur_byte, 8'h84);
        check8("R5 WIP hidden", {7'd0, status_byte[0]}, 8'h00);
        cmd(8'h30);
        check8("R7 resumed", {susp_req, status_byte[0], secur_byte[3:2]}, {1'b0, 1'b1, 2'b00});
        @(negedge clk); eng_done = 1; eng_fail = 1; eng_busy = 0;
        @(negedge clk); eng_done = 0; eng_fail = 0;
        check8("R9 program fail", secur_byte, 8'hA0);
        cmd(8'hB0);
        check8("R8 idle suspend", {7'd0, susp_req}, 8'h00);
        cmd(8'h30);
        check8("R8 stray resume", secur_byte, 8'hA0);
        // erase with suspend, start clears fail
        @(negedge clk); eng_start = 1; eng_erase = 1; eng_busy = 1;
        @(negedge clk); eng_start = 0;
        check8("R9 start clears fail", secur_byte, 8'h80);
        cmd(8'hB0);
        check8("R6 erase suspended", secur_byte, 8'h88);
        cmd(8'h2B);
        check8("R3 read security", rd_byte, 8'h88);
        cmd(8'h30);
        @(negedge clk); eng_done = 1; eng_fail = 1; eng_busy = 0;
        @(negedge clk); eng_done = 0; eng_fail = 0;
        check8("R9 erase fail", secur_byte, 8'hC0);
        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ops [10];
            ops = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h2B, 8'h15, 8'hB0, 8'h30, 8'h68, 8'h9F};
            @(negedge clk);
            cmd_valid = 1'($urandom_range(0, 1));
            cmd_op    = ops[$urandom_range(0, 9)];
            cmd_data  = 8'($urandom);
            cmd_cfg   = 8'($urandom);
            wp_n      = 1'($urandom_range(0, 3) != 0);
            eng_start = ($urandom_range(0, 15) == 0);
            eng_erase = 1'($urandom);
            eng_busy  = ($urandom_range(0, 3) != 0);
            eng_done  = ($urandom_range(0, 7) == 0);
            eng_fail  = 1'($urandom);
        end
        @(negedge clk);
        cmd_valid = 0; eng_start = 0; eng_done = 0;
        idle(2);
        summary();
    end
endmodule